// File: doc/BRIEF.md
# Width-Adaptive Flash Query and Identifier Read Path

This block is the read path that a flash command sequencer switches in while the array is in query mode or identifier mode. It serves the self-description table and the manufacturer and device identifiers for a bank of identical flash devices placed side by side on one data bus. Bank width, device width and the devices' maximum width are parameters of 1, 2 or 4 bytes. A maximum width of zero means "same as the device width".

A bus byte offset is turned into a per-device table index by a right shift. The shift is derived from the three widths. The looked-up byte or identifier is formed into one device's response and then copied into every device slot of the bank. An access wider than the bank is assembled from several bank-width lookups at successive offsets. The table itself is computed at elaboration from the geometry parameters: block count, bank-level sector length, and the identifiers. Read data is registered and appears one cycle after the request.

Top module: `qry_id_responder`

## Requirements
- R1: The table index is the byte offset (`addr_i` plus the slot offset of R6) shifted right by log2(BANK_W) + log2(MAX_DEV_W) - log2(DEV_W). A MAX_DEV_W of 0 is treated as equal to DEV_W.
- R2: In query mode (`mode_i` = 0), an index of 0x52 or above yields a zero table byte.
- R3: When the device width is narrower than the maximum width, queries are answered only if DEV_W = 1, with the table byte repeated across the device lanes. Any other width mismatch makes every query return zero. With matching widths, the bytes of a device response above byte 0 are zero.
- R4: The per-device response is copied into every DEV_W-byte slot of the BANK_W-byte bank response.
- R5: In identifier mode (`mode_i` = 1), only the low 8 index bits are decoded. 0 returns ID0, 1 returns ID1, and anything else returns zero. Each identifier is truncated or zero-extended to DEV_W bytes.
- R6: `size_i` encodes the access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. Bank slot j covers data bytes j*BANK_W upward and is looked up at offset `addr_i` + j*BANK_W. Bytes at or above the access width read as zero.
- R7: The table holds 0x51, 0x52, 0x59 at 0x10..0x12 and 0x01, 0x00 at 0x13/0x14. It holds log2 of one device's size at 0x27 and 0x01 (one uniform region) at 0x2C. Region block count minus one is at 0x2D (low) and 0x2E (high). Per-device sector length divided by 256 is at 0x2F (low) and 0x30 (high).
- R8: The buffered-write size code at table 0x2A is 8 for a 1-byte bank and 11 otherwise. `wbuf_bytes_o` equals 2 raised to that code, times BANK_W/DEV_W.
- R9: `rd_valid_o` is high exactly in the cycle after `rd_en_i` was sampled high. `rd_data_o` updates only then and holds otherwise. Reset clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Read request strobe |
| mode_i | input | 1 | 0 = query table, 1 = identifier |
| addr_i | input | ADDR_W | Bus byte offset |
| size_i | input | 2 | Access width code |
| rd_data_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | Read data valid |
| wbuf_bytes_o | output | 16 | Buffered-write span in bytes |

## Verification
The bench builds three instances. The first is a 2-byte bank of byte-mode parts with a 2-byte maximum width. It reaches the two-bit shift, lane and slot replication, multi-slot packing with offsets that straddle an index boundary, and identifier aliasing through the low index byte. The second is a 4-byte bank of 2-byte parts with a 4-byte maximum width. It reaches the unsupported mismatch that silences queries while identifiers are still replicated per device slot. The third is a 1-byte bank with the maximum width left at zero. It reaches the zero-shift default, four-lookup packing from the low byte upward, and the byte-bank write-size code.

// File: rtl/qry_pkg.sv
package qry_pkg;

  localparam int unsigned QTBL_DEPTH = 'h52;

  typedef enum logic {
    QRY_MODE = 1'b0,
    ID_MODE  = 1'b1
  } rd_mode_e;

  function automatic int unsigned lg2(input int unsigned v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if ((64'd1 << i) < 64'(v)) r = i + 1;
    end
    return r;
  endfunction

  function automatic logic [7:0] qry_table_byte(input logic [6:0] idx,
                                                input int unsigned bank_w,
                                                input int unsigned dev_lg2,
                                                input int unsigned blocks,
                                                input int unsigned sect_dev);
    logic [7:0] b;
    b = 8'h00;
    case (idx)
      7'h10: b = 8'h51;
      7'h11: b = 8'h52;
      7'h12: b = 8'h59;
      7'h13: b = 8'h01;
      7'h15: b = 8'h31;
      7'h1B: b = 8'h45;
      7'h1C: b = 8'h55;
      7'h1F: b = 8'h07;
      7'h20: b = 8'h07;
      7'h21: b = 8'h0A;
      7'h23: b = 8'h04;
      7'h24: b = 8'h04;
      7'h25: b = 8'h04;
      7'h27: b = 8'(dev_lg2);
      7'h28: b = 8'h02;
      7'h2A: b = (bank_w == 1) ? 8'h08 : 8'h0B;
      7'h2C: b = 8'h01;
      7'h2D: b = 8'(blocks - 1);
      7'h2E: b = 8'((blocks - 1) >> 8);
      7'h2F: b = 8'(sect_dev >> 8);
      7'h30: b = 8'(sect_dev >> 16);
      7'h31: b = 8'h50;
      7'h32: b = 8'h52;
      7'h33: b = 8'h49;
      7'h34: b = 8'h31;
      7'h35: b = 8'h30;
      7'h3F: b = 8'h01;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/qry_index.sv
module qry_index #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SHIFT  = 2,
  parameter int unsigned STEP   = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] idx_o
);
  logic [ADDR_W-1:0] slot_addr;
  assign slot_addr = addr_i + ADDR_W'(STEP);
  assign idx_o     = slot_addr >> SHIFT;
endmodule

// File: rtl/qry_lookup.sv
module qry_lookup
  import qry_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned DEV_W    = 1,
  parameter int unsigned MAX_W    = 2,
  parameter int unsigned DEV_LG2  = 21,
  parameter int unsigned BLOCKS   = 64,
  parameter int unsigned SECT_DEV = 32768,
  parameter logic [15:0] ID0      = 16'h0089,
  parameter logic [15:0] ID1      = 16'h0018
) (
  input  logic [ADDR_W-1:0]  idx_i,
  input  logic               mode_i,
  output logic [DEV_W*8-1:0] resp_o
);
  localparam int unsigned DW      = DEV_W * 8;
  localparam bit          LANE_OK = (MAX_W == DEV_W) || (DEV_W == 1 && BANK_W <= 4);
  localparam logic [31:0] ID0_W   = {16'h0000, ID0};
  localparam logic [31:0] ID1_W   = {16'h0000, ID1};

  logic       in_rng;
  logic [7:0] tbl_b;

  assign in_rng = idx_i < ADDR_W'(QTBL_DEPTH);
  assign tbl_b  = qry_table_byte(idx_i[6:0], BANK_W, DEV_LG2, BLOCKS, SECT_DEV);

  // Byte-mode wide part: lanes beyond DEV_W never reach the bus, so byte 0 carries the repeat.
  always_comb begin
    resp_o = '0;
    if (mode_i == QRY_MODE) begin
      if (in_rng && LANE_OK) resp_o[7:0] = tbl_b;
    end else begin
      case (idx_i[7:0])
        8'd0:    resp_o = ID0_W[DW-1:0];
        8'd1:    resp_o = ID1_W[DW-1:0];
        default: resp_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/qry_bank_fill.sv
module qry_bank_fill #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DEV_W  = 1
) (
  input  logic [DEV_W*8-1:0]  dev_i,
  output logic [BANK_W*8-1:0] bank_o
);
  localparam int unsigned NUM_DEV = BANK_W / DEV_W;
  for (genvar s = 0; s < NUM_DEV; s++) begin : g_dev
    assign bank_o[s*DEV_W*8 +: DEV_W*8] = dev_i;
  end
endmodule

// File: rtl/qry_id_responder.sv
module qry_id_responder
  import qry_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned DEV_W      = 1,
  parameter int unsigned MAX_DEV_W  = 2,
  parameter int unsigned NUM_BLOCKS = 64,
  parameter int unsigned SECTOR_LEN = 65536,
  parameter logic [15:0] ID0        = 16'h0089,
  parameter logic [15:0] ID1        = 16'h0018
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic [31:0]       rd_data_o,
  output logic              rd_valid_o,
  output logic [15:0]       wbuf_bytes_o
);
  localparam int unsigned ACC_BYTES = 4;
  localparam int unsigned MAX_W     = (MAX_DEV_W == 0) ? DEV_W : MAX_DEV_W;
  localparam int unsigned NUM_DEV   = BANK_W / DEV_W;
  localparam int unsigned SHIFT     = lg2(BANK_W) + lg2(MAX_W) - lg2(DEV_W);
  localparam int unsigned SLOTS     = ACC_BYTES / BANK_W;
  localparam int unsigned SECT_DEV  = SECTOR_LEN / NUM_DEV;
  localparam int unsigned DEV_LG2   = lg2(SECT_DEV * NUM_BLOCKS);
  localparam int unsigned WBUF_CODE = (BANK_W == 1) ? 8 : 11;
  localparam int unsigned WBUF_B    = (1 << WBUF_CODE) * NUM_DEV;

  logic [ACC_BYTES*8-1:0] packed_w;
  logic [ACC_BYTES*8-1:0] masked_w;
  logic [2:0]             nbytes;

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    logic [ADDR_W-1:0]  idx;
    logic [DEV_W*8-1:0] dev_resp;

    qry_index #(
      .ADDR_W(ADDR_W), .SHIFT(SHIFT), .STEP(j * BANK_W)
    ) u_index (
      .addr_i(addr_i), .idx_o(idx)
    );

    qry_lookup #(
      .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_W(MAX_W),
      .DEV_LG2(DEV_LG2), .BLOCKS(NUM_BLOCKS), .SECT_DEV(SECT_DEV),
      .ID0(ID0), .ID1(ID1)
    ) u_lookup (
      .idx_i(idx), .mode_i(mode_i), .resp_o(dev_resp)
    );

    qry_bank_fill #(
      .BANK_W(BANK_W), .DEV_W(DEV_W)
    ) u_fill (
      .dev_i(dev_resp), .bank_o(packed_w[j*BANK_W*8 +: BANK_W*8])
    );
  end

  assign nbytes = size_i[1] ? 3'd4 : (size_i[0] ? 3'd2 : 3'd1);

  always_comb begin
    for (int b = 0; b < ACC_BYTES; b++) begin
      masked_w[b*8 +: 8] = (3'(b) < nbytes) ? packed_w[b*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= masked_w;
    end
  end

  assign wbuf_bytes_o = 16'(WBUF_B);
endmodule

// File: rtl/qry_id_responder_chk.sv
module qry_id_responder_chk
  import qry_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned DEV_W     = 1,
  parameter int unsigned MAX_DEV_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_en_i,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic [31:0]       rd_data_o,
  input logic              rd_valid_o
);
  localparam int unsigned MAX_W = (MAX_DEV_W == 0) ? DEV_W : MAX_DEV_W;
  localparam int unsigned SHIFT = lg2(BANK_W) + lg2(MAX_W) - lg2(DEV_W);

  logic [ADDR_W-1:0] idx0;
  assign idx0 = addr_i >> SHIFT;

  p_valid_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  p_valid_drops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));
  p_byte_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && size_i == 2'd0) |=> rd_data_o[31:8] == 24'h0);
  p_half_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && size_i == 2'd1) |=> rd_data_o[31:16] == 16'h0);
  p_out_of_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && mode_i == QRY_MODE && size_i == 2'd0 && idx0 >= ADDR_W'(QTBL_DEPTH))
    |=> rd_data_o == 32'h0);
  p_id_other_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && mode_i == ID_MODE && size_i == 2'd0 && idx0[7:1] != 7'd0)
    |=> rd_data_o == 32'h0);
endmodule

bind qry_id_responder qry_id_responder_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAX_DEV_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .mode_i(mode_i),
  .addr_i(addr_i), .size_i(size_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
);

// File: tb/qry_id_responder_tb_top.sv
`timescale 1ns/1ps
module qry_id_responder_tb_top;
  localparam int unsigned AW = 12;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic        en   [3];
  logic        mode [3];
  logic [AW-1:0] addr [3];
  logic [1:0]  size [3];
  logic [31:0] dat  [3];
  logic        vld  [3];
  logic [15:0] wbuf [3];

  item_t q0[$];
  item_t q1[$];
  item_t q2[$];

  int n_tests = 0;
  int n_fail  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // 2-byte bank, byte-mode parts of 2-byte maximum width
  qry_id_responder #(
    .ADDR_W(AW), .BANK_W(2), .DEV_W(1), .MAX_DEV_W(2),
    .NUM_BLOCKS(64), .SECTOR_LEN(65536), .ID0(16'h0089), .ID1(16'h0018)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(en[0]), .mode_i(mode[0]),
    .addr_i(addr[0]), .size_i(size[0]), .rd_data_o(dat[0]),
    .rd_valid_o(vld[0]), .wbuf_bytes_o(wbuf[0])
  );

  // 4-byte bank of 2-byte parts, 4-byte maximum: unsupported mismatch
  qry_id_responder #(
    .ADDR_W(AW), .BANK_W(4), .DEV_W(2), .MAX_DEV_W(4),
    .NUM_BLOCKS(64), .SECTOR_LEN(65536), .ID0(16'h0089), .ID1(16'h0018)
  ) dut_u (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(en[1]), .mode_i(mode[1]),
    .addr_i(addr[1]), .size_i(size[1]), .rd_data_o(dat[1]),
    .rd_valid_o(vld[1]), .wbuf_bytes_o(wbuf[1])
  );

  // 1-byte bank, maximum width left at zero
  qry_id_responder #(
    .ADDR_W(AW), .BANK_W(1), .DEV_W(1), .MAX_DEV_W(0),
    .NUM_BLOCKS(16), .SECTOR_LEN(4096), .ID0(16'h0089), .ID1(16'h0018)
  ) dut_z (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(en[2]), .mode_i(mode[2]),
    .addr_i(addr[2]), .size_i(size[2]), .rd_data_o(dat[2]),
    .rd_valid_o(vld[2]), .wbuf_bytes_o(wbuf[2])
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic issue(input int d, input logic m, input logic [AW-1:0] a,
                       input logic [1:0] s, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    for (int k = 0; k < 3; k++) en[k] = 1'b0;
    en[d] = 1'b1; mode[d] = m; addr[d] = a; size[d] = s;
    it.exp = exp; it.tag = tag;
    case (d)
      0: q0.push_back(it);
      1: q1.push_back(it);
      default: q2.push_back(it);
    endcase
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int e = 0; e < 3; e++) en[e] = 1'b0;
    end
  endtask

  task automatic pop_cmp(input int d, input logic [31:0] act);
    item_t it;
    int sz;
    sz = (d == 0) ? q0.size() : ((d == 1) ? q1.size() : q2.size());
    if (sz == 0) begin
      check("R9 unexpected valid", 32'h1, 32'h0);
    end else begin
      case (d)
        0: it = q0.pop_front();
        1: it = q1.pop_front();
        default: it = q2.pop_front();
      endcase
      check(it.tag, act, it.exp);
    end
  endtask

  // Monitor: compare each valid result against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < 3; d++) begin
        if (vld[d]) pop_cmp(d, dat[d]);
      end
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      en[k] = 1'b0; mode[k] = 1'b0; addr[k] = '0; size[k] = 2'd0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset valid", 32'(vld[0]), 32'h0);
    check("R9 reset data",  dat[0], 32'h0);
    rst_n = 1'b1;
    check("R8 wbuf 2-byte bank", 32'(wbuf[0]), 32'd4096);
    check("R8 wbuf 4-byte bank", 32'(wbuf[1]), 32'd4096);
    check("R8 wbuf 1-byte bank", 32'(wbuf[2]), 32'd256);

    // dut_i: shift 2, byte repeated across the two bank bytes
    issue(0, 1'b0, 12'h040, 2'd1, 32'h0000_5151, "R1 R4 query 0x10 half");
    issue(0, 1'b0, 12'h040, 2'd0, 32'h0000_0051, "R6 query byte access");
    issue(0, 1'b0, 12'h044, 2'd2, 32'h5252_5252, "R6 query word same index");
    issue(0, 1'b0, 12'h047, 2'd2, 32'h5959_5252, "R6 slot straddles index");
    issue(0, 1'b0, 12'h09C, 2'd1, 32'h0000_1515, "R7 device size log2");
    issue(0, 1'b0, 12'h04C, 2'd1, 32'h0000_0101, "R7 command set");
    issue(0, 1'b0, 12'h0B0, 2'd1, 32'h0000_0101, "R7 region count");
    issue(0, 1'b0, 12'h0B4, 2'd1, 32'h0000_3F3F, "R7 blocks minus one low");
    issue(0, 1'b0, 12'h0B8, 2'd1, 32'h0000_0000, "R7 blocks minus one high");
    issue(0, 1'b0, 12'h0BC, 2'd1, 32'h0000_8080, "R7 sector/256 low");
    issue(0, 1'b0, 12'h0A8, 2'd1, 32'h0000_0B0B, "R8 write size code");
    issue(0, 1'b0, 12'h0FC, 2'd1, 32'h0000_0101, "R7 last populated entry");
    issue(0, 1'b0, 12'h148, 2'd1, 32'h0000_0000, "R2 index 0x52");
    issue(0, 1'b0, 12'h440, 2'd1, 32'h0000_0000, "R2 index 0x110 no alias");
    issue(0, 1'b1, 12'h000, 2'd1, 32'h0000_8989, "R5 R4 ident 0");
    issue(0, 1'b1, 12'h004, 2'd1, 32'h0000_1818, "R5 ident 1");
    issue(0, 1'b1, 12'h008, 2'd1, 32'h0000_0000, "R5 ident other");
    issue(0, 1'b1, 12'h404, 2'd1, 32'h0000_1818, "R5 low index byte only");
    issue(0, 1'b1, 12'h000, 2'd2, 32'h8989_8989, "R6 ident word");
    idle(3);
    check("R9 valid low when idle", 32'(vld[0]), 32'h0);
    check("R9 data holds", dat[0], 32'h8989_8989);

    // dut_u: unsupported mismatch
    issue(1, 1'b0, 12'h080, 2'd2, 32'h0000_0000, "R3 mismatch silences query");
    issue(1, 1'b1, 12'h000, 2'd2, 32'h0089_0089, "R4 R5 ident 0 per device slot");
    issue(1, 1'b1, 12'h008, 2'd2, 32'h0018_0018, "R1 R5 ident 1 shift 3");
    idle(2);

    // dut_z: 1-byte bank, zero shift
    issue(2, 1'b0, 12'h010, 2'd2, 32'h0159_5251, "R1 R6 four lookups packed");
    issue(2, 1'b0, 12'h027, 2'd0, 32'h0000_0010, "R7 device size 1-byte bank");
    issue(2, 1'b0, 12'h02A, 2'd0, 32'h0000_0008, "R8 byte-bank code");
    issue(2, 1'b0, 12'h02D, 2'd0, 32'h0000_000F, "R7 blocks minus one");
    issue(2, 1'b0, 12'h02F, 2'd1, 32'h0000_0010, "R7 sector/256 pair");
    issue(2, 1'b1, 12'h001, 2'd0, 32'h0000_0018, "R5 ident 1 byte");
    issue(2, 1'b1, 12'h000, 2'd1, 32'h0000_1889, "R6 ident pair");
    idle(3);

    check("R9 scoreboard drained", 32'(q0.size() + q1.size() + q2.size()), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R9 watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule